// File: doc/BRIEF.md
# DQS Read-Capture Delay Calibrator

This block picks a read-capture delay setting for two DQS byte lanes. It tries every setting of the delay line in turn. For each setting it puts the same tap value on both lanes and asks an external memory self-test engine to run a test. It then waits for that engine to report completion and withdraws the run request. After that it judges the tap by the compare count the engine returns. The engine is outside this block and is reached only through a run/finished/count handshake. The delay lines are also outside the block and simply follow the two tap outputs.

Once every tap has been tried, the block records the lowest and highest passing taps. It programs the point halfway between them, rounded down, onto both lanes. If no tap passed, it restores the tap value that was presented when calibration began. A programmable time limit on each test keeps a silent engine from stalling the sweep: a test that runs out of time counts as a failing tap.

The controller has six states:
- CAL_IDLE: waits for a start request.
- CAL_APPLY: loads the sweep tap onto the lanes.
- CAL_WAIT: holds the run request until the engine finishes or the time limit expires.
- CAL_STOP: drops the run request, judges the tap, then advances to the next tap or, after the last tap, goes to CAL_FINISH.
- CAL_FINISH: writes the chosen tap.
- CAL_DONE: raises the completion pulse, then returns to CAL_IDLE.

Top module: `dqs_tap_sweep_cal`

## Requirements
- R1: One calibration runs exactly 2^TAP_W tests (64 by default), one per tap, in increasing order starting at tap 0.
- R2: At each run request, both lane outputs carry the same tap value, and that value does not change while the run request is high.
- R3: A tap passes only when the count returned with the finished flag equals EXPECT_CNT (8 by default). Counts of 7 or 9 fail.
- R4: The run request stays high until the finished flag is seen, and it is low in the cycle after the flag is seen, before the tap is judged.
- R5: When at least one tap passed, the final tap is floor((lowest passing + highest passing) / 2) modulo 2^TAP_W. Taps that fail between those two do not change the result.
- R6: When no tap passed, the final tap equals the tap_init value sampled on the accepted start request.
- R7: pass_count equals the number of passing taps when cal_done is high, and it never exceeds 2^TAP_W.
- R8: When the finished flag does not arrive, the run request is high for tmo_limit+1 cycles and then drops, and that tap counts as failing.
- R9: cal_done is high for exactly one cycle per calibration. In that cycle both lanes already carry the final tap. cal_busy is low in the following cycle.
- R10: A start request while cal_busy is high is ignored: the sweep is not restarted and the saved fallback tap is not replaced.
- R11: After reset, cal_busy, cal_done, bist_run and pass_count are 0, and both lanes carry tap 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Start request; honoured only while idle |
| tap_init | input | TAP_W | Current tap, kept as the fallback result |
| tmo_limit | input | TMO_W | Time limit for one test, in cycles beyond the first |
| bist_run | output | 1 | Run request to the self-test engine |
| bist_finished | input | 1 | Engine reports the test is complete |
| bist_count | input | CNT_W | Compare count reported by the engine |
| tap_lane0 | output | TAP_W | Delay tap for byte lane 0 |
| tap_lane1 | output | TAP_W | Delay tap for byte lane 1 |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle pulse when the final tap is in place |
| pass_count | output | PASS_W | Number of passing taps in the last sweep |

## Verification
The bench uses the default parameters: 64 taps, an 8-bit count, an expected count of 8, and a 7-bit pass counter. With these values it can reach both edge taps (0 and 63), a full 64-tap pass that fills the counter to its top, and the modulo of the midpoint. Its engine model answers the failing taps with 7 or 9, so the count comparison is tested right at its boundary. The model can also stay silent on chosen taps, which exercises the time limit at a small tmo_limit.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;

    typedef enum logic [2:0] {
        CAL_IDLE   = 3'd0,
        CAL_APPLY  = 3'd1,
        CAL_WAIT   = 3'd2,
        CAL_STOP   = 3'd3,
        CAL_FINISH = 3'd4,
        CAL_DONE   = 3'd5
    } cal_state_t;

endpackage

// File: rtl/dqs_cal_timer.sv
module dqs_cal_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] elapsed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (!run) begin
            elapsed_q <= '0;
        end else if (elapsed_q != limit) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    assign expired = run && (elapsed_q == limit);

endmodule

// File: rtl/dqs_cal_window.sv
module dqs_cal_window #(
    parameter int TAP_W  = 6,
    parameter int PASS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              update,
    input  logic              pass,
    input  logic [TAP_W-1:0]  tap,
    output logic              any_pass,
    output logic [PASS_W-1:0] pass_count,
    output logic [TAP_W-1:0]  mid_tap
);

    localparam int NUM_TAPS = 1 << TAP_W;
    localparam int FW       = TAP_W + 1;
    // Out-of-range value marks "no passing tap recorded yet".
    localparam logic [FW-1:0] SENTINEL = FW'(NUM_TAPS);

    logic [FW-1:0]     low_q;
    logic [TAP_W-1:0]  high_q;
    logic [PASS_W-1:0] cnt_q;
    logic [TAP_W:0]    sum;
    logic [TAP_W:0]    half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q  <= SENTINEL;
            high_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            low_q  <= SENTINEL;
            high_q <= '0;
            cnt_q  <= '0;
        end else if (update && pass) begin
            if (low_q == SENTINEL) begin
                low_q <= {1'b0, tap};
            end
            high_q <= tap;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        sum  = {1'b0, low_q[TAP_W-1:0]} + {1'b0, high_q};
        half = sum >> 1;
    end

    // Modulo the tap range: keep the low TAP_W bits.
    assign mid_tap    = half[TAP_W-1:0];
    assign any_pass   = (low_q != SENTINEL);
    assign pass_count = cnt_q;

endmodule

// File: rtl/dqs_tap_sweep_cal.sv
module dqs_tap_sweep_cal #(
    parameter int TAP_W      = 6,
    parameter int CNT_W      = 8,
    parameter int EXPECT_CNT = 8,
    parameter int TMO_W      = 16,
    parameter int PASS_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic [TAP_W-1:0]  tap_init,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              bist_run,
    input  logic              bist_finished,
    input  logic [CNT_W-1:0]  bist_count,
    output logic [TAP_W-1:0]  tap_lane0,
    output logic [TAP_W-1:0]  tap_lane1,
    output logic              cal_busy,
    output logic              cal_done,
    output logic [PASS_W-1:0] pass_count
);
    import dqs_cal_pkg::*;

    localparam logic [TAP_W-1:0] LAST_TAP  = {TAP_W{1'b1}};
    localparam logic [CNT_W-1:0] GOOD_CNT  = CNT_W'(EXPECT_CNT);

    cal_state_t        state_q, state_d;
    logic [TAP_W-1:0]  sweep_q;
    logic [TAP_W-1:0]  lane_q;
    logic [TAP_W-1:0]  saved_q;
    logic              verdict_q;
    logic              tmo_hit;
    logic              win_any;
    logic [TAP_W-1:0]  win_mid;
    logic              accept;

    assign accept = (state_q == CAL_IDLE) && cal_start;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_IDLE:   if (cal_start) state_d = CAL_APPLY;
            CAL_APPLY:  state_d = CAL_WAIT;
            CAL_WAIT:   if (bist_finished || tmo_hit) state_d = CAL_STOP;
            CAL_STOP:   state_d = (sweep_q == LAST_TAP) ? CAL_FINISH : CAL_APPLY;
            CAL_FINISH: state_d = CAL_DONE;
            CAL_DONE:   state_d = CAL_IDLE;
            default:    state_d = CAL_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        bist_run = 1'b0;
        cal_busy = 1'b1;
        cal_done = 1'b0;
        unique case (state_q)
            CAL_IDLE:   cal_busy = 1'b0;
            CAL_WAIT:   bist_run = 1'b1;
            CAL_DONE:   cal_done = 1'b1;
            default:    ;
        endcase
    end

    // Sweep datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sweep_q   <= '0;
            lane_q    <= '0;
            saved_q   <= '0;
            verdict_q <= 1'b0;
        end else begin
            unique case (state_q)
                CAL_IDLE: begin
                    if (cal_start) begin
                        saved_q <= tap_init;
                        sweep_q <= '0;
                    end
                end
                CAL_APPLY: begin
                    lane_q <= sweep_q;
                end
                CAL_WAIT: begin
                    if (bist_finished) begin
                        verdict_q <= (bist_count == GOOD_CNT);
                    end else if (tmo_hit) begin
                        verdict_q <= 1'b0;
                    end
                end
                CAL_STOP: begin
                    if (sweep_q != LAST_TAP) begin
                        sweep_q <= sweep_q + 1'b1;
                    end
                end
                CAL_FINISH: begin
                    lane_q <= win_any ? win_mid : saved_q;
                end
                CAL_DONE: ;
                default: ;
            endcase
        end
    end

    dqs_cal_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == CAL_WAIT),
        .limit   (tmo_limit),
        .expired (tmo_hit)
    );

    dqs_cal_window #(
        .TAP_W  (TAP_W),
        .PASS_W (PASS_W)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .update     (state_q == CAL_STOP),
        .pass       (verdict_q),
        .tap        (sweep_q),
        .any_pass   (win_any),
        .pass_count (pass_count),
        .mid_tap    (win_mid)
    );

    assign tap_lane0 = lane_q;
    assign tap_lane1 = lane_q;

endmodule

// File: rtl/dqs_tap_sweep_cal_sva.sv
module dqs_tap_sweep_cal_sva #(
    parameter int TAP_W  = 6,
    parameter int TMO_W  = 16,
    parameter int PASS_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TMO_W-1:0]  tmo_limit,
    input logic              bist_run,
    input logic              bist_finished,
    input logic [TAP_W-1:0]  tap_lane0,
    input logic [TAP_W-1:0]  tap_lane1,
    input logic              cal_busy,
    input logic              cal_done,
    input logic [PASS_W-1:0] pass_count
);
    localparam int NUM_TAPS = 1 << TAP_W;

    logic [TMO_W:0]   high_len;
    logic [TAP_W-1:0] prev_tap;
    logic             launched;
    logic             run_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_len <= '0;
            prev_tap <= '0;
            launched <= 1'b0;
            run_prev <= 1'b0;
        end else begin
            run_prev <= bist_run;
            high_len <= bist_run ? high_len + 1'b1 : '0;
            if (cal_done) begin
                launched <= 1'b0;
            end else if (bist_run && !run_prev) begin
                launched <= 1'b1;
                prev_tap <= tap_lane0;
            end
        end
    end

    assert_sweep_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_run && !run_prev && launched) |-> (tap_lane0 == TAP_W'(prev_tap + 1'b1)));

    assert_lanes_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_run && run_prev) |-> ($stable(tap_lane0) && tap_lane0 == tap_lane1));

    assert_run_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_run && bist_finished) |=> !bist_run);

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pass_count) <= NUM_TAPS);

    assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bist_run |-> (high_len <= {1'b0, tmo_limit}));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> (!cal_done && !cal_busy));

    assert_run_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bist_run |-> cal_busy);

endmodule

bind dqs_tap_sweep_cal dqs_tap_sweep_cal_sva #(
    .TAP_W  (TAP_W),
    .TMO_W  (TMO_W),
    .PASS_W (PASS_W)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .tmo_limit     (tmo_limit),
    .bist_run      (bist_run),
    .bist_finished (bist_finished),
    .tap_lane0     (tap_lane0),
    .tap_lane1     (tap_lane1),
    .cal_busy      (cal_busy),
    .cal_done      (cal_done),
    .pass_count    (pass_count)
);

// File: tb/dqs_tap_sweep_cal_test.sv
module dqs_tap_sweep_cal_test;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_start = 1'b0;
    logic [5:0]  tap_init = '0;
    logic [15:0] tmo_limit = 16'd50;
    logic        bist_run;
    logic        bist_finished = 1'b0;
    logic [7:0]  bist_count = '0;
    logic [5:0]  tap_lane0, tap_lane1;
    logic        cal_busy, cal_done;
    logic [6:0]  pass_count;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [63:0] pmask = '0;
    logic [63:0] hmask = '0;
    int lat_cnt = 0;

    int sweep_idx = 0, order_err = 0, done_cnt = 0, cur_high = 0, max_high = 0;
    logic run_prev = 1'b0;
    int fin_tap0 = 0, fin_tap1 = 0, fin_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dqs_tap_sweep_cal uut (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .tap_init(tap_init),
        .tmo_limit(tmo_limit), .bist_run(bist_run), .bist_finished(bist_finished),
        .bist_count(bist_count), .tap_lane0(tap_lane0), .tap_lane1(tap_lane1),
        .cal_busy(cal_busy), .cal_done(cal_done), .pass_count(pass_count)
    );

    // Self-test engine model: answers LAT+1 edges after the request, or never on hung taps.
    always @(posedge clk) begin
        if (!bist_run) begin
            bist_finished <= 1'b0;
            lat_cnt <= 0;
        end else if (!bist_finished && !hmask[tap_lane0]) begin
            if (lat_cnt == LAT) begin
                bist_finished <= 1'b1;
                bist_count <= pmask[tap_lane0] ? 8'd8 : (tap_lane0[0] ? 8'd9 : 8'd7);
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // Monitor on the falling edge
    always @(negedge clk) begin
        cycles++;
        if (bist_run && !run_prev) begin
            if (int'(tap_lane0) != (sweep_idx % 64) || tap_lane1 != tap_lane0) order_err++;
            sweep_idx++;
        end
        if (bist_run) begin
            cur_high++;
            if (cur_high > max_high) max_high = cur_high;
        end else begin
            cur_high = 0;
        end
        if (cal_done) done_cnt++;
        run_prev = bist_run;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_cal(input logic [63:0] m, input logic [63:0] h, input int init,
                           input int tmo, input int poke_at, input int poke_init);
        int guard;
        pmask = m; hmask = h; tap_init = 6'(init); tmo_limit = 16'(tmo);
        sweep_idx = 0; order_err = 0; done_cnt = 0; max_high = 0;
        @(negedge clk) cal_start = 1'b1;
        @(negedge clk) cal_start = 1'b0;
        guard = 0;
        while (!cal_done && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (guard == poke_at) begin
                tap_init = 6'(poke_init);
                cal_start = 1'b1;
            end else begin
                cal_start = 1'b0;
            end
        end
        cal_start = 1'b0;
        fin_tap0 = tap_lane0; fin_tap1 = tap_lane1; fin_cnt = pass_count;
        repeat (3) @(negedge clk);
    endtask

    // {pass mask, tap_init, expected tap, expected pass count}
    localparam logic [82:0] VEC [0:5] = '{
        {64'h0000_0000_001F_FC00, 6'd5,  6'd15, 7'd11},
        {64'h0000_0000_0000_0000, 6'd37, 6'd37, 7'd0},
        {64'hFFFF_FFFF_FFFF_FFFF, 6'd12, 6'd31, 7'd64},
        {64'h8000_0000_0000_0000, 6'd0,  6'd63, 7'd1},
        {64'h0000_0100_0000_000C, 6'd20, 6'd21, 7'd3},
        {64'h0000_0000_0000_0001, 6'd50, 6'd0,  7'd1}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 busy", int'(cal_busy), 0);
        chk("R11 run", int'(bist_run), 0);
        chk("R11 lanes", int'(tap_lane0) + int'(tap_lane1), 0);
        chk("R11 count", int'(pass_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 done", int'(cal_done), 0);

        for (int i = 0; i < 6; i++) begin
            run_cal(VEC[i][82:19], 64'h0, int'(VEC[i][18:13]), 50, -1, 0);
            chk("R5/R6/R3 final tap", fin_tap0, int'(VEC[i][12:7]));
            chk("R2 lane1 final", fin_tap1, int'(VEC[i][12:7]));
            chk("R7 pass count", fin_cnt, int'(VEC[i][6:0]));
            chk("R1 sweep order errors", order_err, 0);
            chk("R1 sweep length", sweep_idx, 64);
            chk("R9 done pulses", done_cnt, 1);
            chk("R4 run high cycles", max_high, LAT + 2);
        end

        // R8: silent engine on taps 30..33 within passing 28..35
        run_cal(64'h0000_000F_F000_0000, 64'h0000_0003_C000_0000, 7, 4, -1, 0);
        chk("R8 final tap", fin_tap0, 31);
        chk("R8 pass count", fin_cnt, 4);
        chk("R8 run high on timeout", max_high, 5);
        chk("R8 sweep length", sweep_idx, 64);

        // R10: start request mid-sweep with another tap_init is ignored
        run_cal(64'h0, 64'h0, 12, 50, 40, 9);
        chk("R10 fallback kept", fin_tap0, 12);
        chk("R10 sweep length", sweep_idx, 64);
        chk("R10 done pulses", done_cnt, 1);
        chk("R10 order", order_err, 0);
        chk("R10 idle after", int'(cal_busy), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule